// File: doc/BRIEF.md
# Three-Carrier Shoot-Through PWM Modulator

This block generates the gate pattern for a three-phase, two-level bridge that sits behind a switched boost stage with its own boost switch. Three phase reference samples, a shoot-through duty value and a carrier half-period come in. Seven gate requests go out: an upper and a lower gate for each of the three legs, and one gate for the boost switch. The block builds three triangle carriers from synchronous up/down counters. One carrier serves the bridge. The other two serve the boost switch, and each booster carrier is displaced from the one before it by one sixth of a carrier cycle.

Each reference first has a common zero-sequence offset added, which centres the three samples around mid-scale. It is then compared against the bridge carrier. The shoot-through bands sit at the top and bottom of the bridge carrier, and while a band is active every leg is shorted. The boost switch fires in the same bands on the two booster carriers and is held off whenever the bridge is shorted. The result is six evenly spaced charging pulses per carrier cycle: two of them through the bridge and four through the boost switch.

References and duty are sampled once per carrier cycle, at the valley. This keeps a carrier period free of mid-period changes. Values are unsigned fixed point, where 2^DATA_W stands for 1.0.

Top module: `st_boost_pwm`

## Requirements
- R1: `rst` is synchronous and active high. From the first clock edge at which `rst` is high, all seven gates are low. `half_period` is captured only while `rst` is high, and a value below 3 is raised to 3; this captured value is H below.
- R2: Each carrier steps by one per clock between 0 and H, so its period is 2H cycles. After reset the bridge carrier starts at 0, booster 1 starts at floor(H/3) and booster 2 starts at 2*floor(H/3), all rising. When pulses do not overlap, a boost pulse therefore begins floor(H/3) cycles after each shoot-through pulse begins.
- R3: The shifted reference for phase x is floor((2*ref_x + 2^W - max - min)/2), where max and min are taken over the three latched references.
- R4: Leg x is in its upper state when shifted_x*H > c*2^W, where c is the bridge carrier value.
- R5: The shoot-through band is active when c*2^W < d*H or when c*2^W > (2^W - d)*H, with d the latched duty. A duty of 0 gives no shoot-through at all.
- R6: Gates are registered one clock after the carrier state: gate_hi[x] = up_x OR ST and gate_lo[x] = (NOT up_x) OR ST. Bit 0 is phase a, bit 1 is phase b and bit 2 is phase c.
- R7: `gate_boost` is high when either booster carrier lies in the R5 band (same duty d) and the bridge is not in shoot-through.
- R8: When the pulses do not overlap, every 2H-cycle window holds exactly two shoot-through pulses and four boost pulses, all of the same width.
- R9: References and duty are latched only in cycles where the bridge carrier is 0, and during reset. A change made at any other time leaves the gates unchanged until the next valley.
- R10: A duty above 2^(W-1) is treated as exactly 2^(W-1).
- R11: `gate_boost` is never high while the legs are shorted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also captures the half-period |
| half_period | input | CNT_W | Carrier half-period in clock cycles |
| duty_st | input | DATA_W | Shoot-through and boost band duty, 2^DATA_W = 1.0 |
| ref_a | input | DATA_W | Phase a reference |
| ref_b | input | DATA_W | Phase b reference |
| ref_c | input | DATA_W | Phase c reference |
| gate_hi | output | 3 | Upper gate per leg, bit 0 = a |
| gate_lo | output | 3 | Lower gate per leg, bit 0 = a |
| gate_boost | output | 1 | Boost switch gate |

## Verification
Three equal mid-scale references with zero duty isolate the compare against the bridge carrier. Two unbalanced sets, one of them with an odd max+min sum, show whether the offset is applied and whether it is rounded down. A small duty at two half-periods yields separated pulses, so the test can check counts, widths and the floor(H/3) spacing between shoot-through and boost pulses. An oversized duty drives the bands into overlap, which exposes both the clamp and the masking of the boost gate. Changing a reference just after a falling leg edge, and a half-period below the minimum, show whether latching happens only at the valley and whether the minimum is enforced.

// File: rtl/stbp_pkg.sv
package stbp_pkg;
  localparam int PHASES   = 3;
  localparam int CARRIERS = 3;

  typedef struct packed {
    logic [PHASES-1:0] hi;
    logic [PHASES-1:0] lo;
    logic              boost;
  } gate_set_t;
endpackage

// File: rtl/stbp_carrier.sv
module stbp_carrier #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] half,
  input  logic [CNT_W-1:0] start,
  output logic [CNT_W-1:0] level
);
  logic rising;

  always_ff @(posedge clk) begin
    if (rst) begin
      level  <= start;
      rising <= 1'b1;
    end else if (rising) begin
      if (level >= half - 1'b1) begin
        level  <= half;
        rising <= 1'b0;
      end else begin
        level <= level + 1'b1;
      end
    end else begin
      if (level <= CNT_W'(1)) begin
        level  <= '0;
        rising <= 1'b1;
      end else begin
        level <= level - 1'b1;
      end
    end
  end

  AST_TRI_BOUND: assert property (@(posedge clk) disable iff (rst) level <= half); // R2
  AST_TRI_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((level == $past(level) + 1'b1) || (level == $past(level) - 1'b1))); // R2
endmodule

// File: rtl/stbp_band.sv
module stbp_band #(
  parameter int DATA_W = 12,
  parameter int CNT_W  = 10
) (
  input  logic [CNT_W-1:0]  level,
  input  logic [CNT_W-1:0]  half,
  input  logic [DATA_W-1:0] duty,
  output logic              in_band
);
  localparam int PW = DATA_W + CNT_W + 1;
  localparam logic [PW-1:0] FULL = PW'(1) << DATA_W;

  function automatic logic edge_zone(input logic [CNT_W-1:0] lv,
                                     input logic [CNT_W-1:0] hp,
                                     input logic [DATA_W-1:0] dt);
    logic [PW-1:0] scaled, low_lim, high_lim;
    scaled   = PW'(lv) << DATA_W;
    low_lim  = PW'(dt) * PW'(hp);
    high_lim = (FULL - PW'(dt)) * PW'(hp);
    return (scaled < low_lim) || (scaled > high_lim);
  endfunction

  assign in_band = edge_zone(level, half, duty);
endmodule

// File: rtl/stbp_zsoffset.sv
module stbp_zsoffset #(
  parameter int DATA_W = 12
) (
  input  logic [2:0][DATA_W-1:0] raw,
  output logic [2:0][DATA_W-1:0] shifted
);
  localparam int SW = DATA_W + 2;
  localparam logic [SW-1:0] FULL = SW'(1) << DATA_W;

  function automatic logic [DATA_W-1:0] big3(input logic [2:0][DATA_W-1:0] v);
    logic [DATA_W-1:0] m;
    m = (v[0] > v[1]) ? v[0] : v[1];
    return (m > v[2]) ? m : v[2];
  endfunction

  function automatic logic [DATA_W-1:0] small3(input logic [2:0][DATA_W-1:0] v);
    logic [DATA_W-1:0] m;
    m = (v[0] < v[1]) ? v[0] : v[1];
    return (m < v[2]) ? m : v[2];
  endfunction

  function automatic logic [DATA_W-1:0] centre(input logic [DATA_W-1:0] v,
                                               input logic [DATA_W-1:0] hi,
                                               input logic [DATA_W-1:0] lo);
    logic [SW-1:0] twice;
    twice = (SW'(v) << 1) + FULL - SW'(hi) - SW'(lo);
    return DATA_W'(twice >> 1);
  endfunction

  logic [DATA_W-1:0] top_v, bot_v;
  assign top_v = big3(raw);
  assign bot_v = small3(raw);

  for (genvar x = 0; x < 3; x++) begin : g_ph
    assign shifted[x] = centre(raw[x], top_v, bot_v);
  end
endmodule

// File: rtl/st_boost_pwm.sv
module st_boost_pwm
  import stbp_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int CNT_W    = 10,
  parameter int MIN_HALF = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  half_period,
  input  logic [DATA_W-1:0] duty_st,
  input  logic [DATA_W-1:0] ref_a,
  input  logic [DATA_W-1:0] ref_b,
  input  logic [DATA_W-1:0] ref_c,
  output logic [2:0]        gate_hi,
  output logic [2:0]        gate_lo,
  output logic              gate_boost
);
  localparam int PW = DATA_W + CNT_W + 1;
  localparam logic [DATA_W-1:0] HALF_FS = DATA_W'(1) << (DATA_W - 1);

  function automatic logic leg_up(input logic [DATA_W-1:0] r,
                                  input logic [CNT_W-1:0] lv,
                                  input logic [CNT_W-1:0] hp);
    return (PW'(r) * PW'(hp)) > (PW'(lv) << DATA_W);
  endfunction

  function automatic logic [DATA_W-1:0] duty_limit(input logic [DATA_W-1:0] d);
    return (d > HALF_FS) ? HALF_FS : d;
  endfunction

  // period capture
  logic [CNT_W-1:0] half_eff, half_q, third;
  assign half_eff = (half_period < CNT_W'(MIN_HALF)) ? CNT_W'(MIN_HALF) : half_period;
  assign third    = half_eff / CNT_W'(3);

  always_ff @(posedge clk) begin
    if (rst) half_q <= half_eff;
  end

  // carriers: index 0 bridge, 1 and 2 boost
  logic [CNT_W-1:0] lvl [CARRIERS];
  logic             band [CARRIERS];
  logic [DATA_W-1:0] duty_q;

  for (genvar k = 0; k < CARRIERS; k++) begin : g_car
    logic [CNT_W-1:0] start_pos;
    assign start_pos = CNT_W'(k) * third;
    stbp_carrier #(.CNT_W(CNT_W)) u_car (
      .clk(clk), .rst(rst), .half(half_q), .start(start_pos), .level(lvl[k])
    );
    stbp_band #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_band (
      .level(lvl[k]), .half(half_q), .duty(duty_q), .in_band(band[k])
    );
  end

  // valley latch
  logic                     valley_i;
  logic [2:0][DATA_W-1:0]   ref_q, ref_sh;
  assign valley_i = (lvl[0] == '0);

  always_ff @(posedge clk) begin
    if (rst || valley_i) begin
      ref_q  <= {ref_c, ref_b, ref_a};
      duty_q <= duty_limit(duty_st);
    end
  end

  stbp_zsoffset #(.DATA_W(DATA_W)) u_zs (.raw(ref_q), .shifted(ref_sh));

  // compare and overlay
  logic [PHASES-1:0] up_now;
  logic              st_now, boost_now;

  for (genvar x = 0; x < PHASES; x++) begin : g_leg
    assign up_now[x] = leg_up(ref_sh[x], lvl[0], half_q);
  end

  assign st_now    = band[0];
  assign boost_now = (band[1] | band[2]) & ~st_now;

  gate_set_t gs_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      gs_q <= '0;
    end else begin
      gs_q.hi    <= up_now | {PHASES{st_now}};
      gs_q.lo    <= ~up_now | {PHASES{st_now}};
      gs_q.boost <= boost_now;
    end
  end

  assign gate_hi    = gs_q.hi;
  assign gate_lo    = gs_q.lo;
  assign gate_boost = gs_q.boost;

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (gate_hi == '0 && gate_lo == '0 && !gate_boost)); // R1
  AST_ST_SHORTS_LEGS: assert property (@(posedge clk) disable iff (rst)
    st_now |=> (&(gate_hi & gate_lo))); // R6
  AST_LEGS_TOGETHER: assert property (@(posedge clk) disable iff (rst)
    ((gate_hi & gate_lo) == '0) || (&(gate_hi & gate_lo))); // R6
  AST_ST_BLOCKS_BOOST: assert property (@(posedge clk) disable iff (rst)
    st_now |=> !gate_boost); // R7
  AST_BOOST_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(gate_boost && gate_hi[0] && gate_lo[0])); // R11
  AST_DUTY_CLAMP: assert property (@(posedge clk) disable iff (rst)
    duty_q <= HALF_FS); // R10
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    !valley_i |=> ($stable(duty_q) && $stable(ref_q))); // R9
endmodule

// File: tb/st_boost_pwm_tb.sv
`timescale 1ns/1ps
module st_boost_pwm_tb;
  localparam int W  = 12;
  localparam int CW = 10;
  localparam int FS = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CW-1:0] half_period = 10'd48;
  logic [W-1:0]  duty_st = '0, ref_a = 12'd2048, ref_b = 12'd2048, ref_c = 12'd2048;
  logic [2:0]    gate_hi, gate_lo;
  logic          gate_boost;

  always #2 clk = ~clk;

  st_boost_pwm #(.DATA_W(W), .CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst), .half_period(half_period), .duty_st(duty_st),
    .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .gate_boost(gate_boost)
  );

  int checks = 0, errors = 0, cur_h = 48;
  int e_hi[3], e_st, e_s, e_per;
  int m_hi[3], m_st, m_s, m_rise[2], m_wmin[2], m_wmax[2];
  int m_both, m_leg_bad, m_gap_bad, m_gap_seen;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int fold(input int p, input int h);
    int q = p % (2 * h);
    return (q <= h) ? q : 2 * h - q;
  endfunction

  function automatic bit zone(input int c, input int h, input int d);
    return (c * FS < d * h) || (c * FS > (FS - d) * h);
  endfunction

  task automatic predict(input int h_in, input int d_in, input int ra, input int rb, input int rc);
    int h  = (h_in < 3) ? 3 : h_in;
    int d  = (d_in > FS / 2) ? FS / 2 : d_in;
    int th = h / 3;
    int r[3] = '{ra, rb, rc};
    int mx = (ra > rb) ? ra : rb;
    int mn = (ra < rb) ? ra : rb;
    int sh[3];
    if (rc > mx) mx = rc;
    if (rc < mn) mn = rc;
    for (int x = 0; x < 3; x++) begin
      sh[x] = (2 * r[x] + FS - mx - mn) / 2;
      e_hi[x] = 0;
    end
    e_st = 0; e_s = 0; e_per = 2 * h;
    for (int p = 0; p < 2 * h; p++) begin
      int  ci = fold(p, h);
      bit  st = zone(ci, h, d);
      bit  bz = zone(fold(p + th, h), h, d) || zone(fold(p + 2 * th, h), h, d);
      e_st += st;
      e_s  += (bz && !st);
      for (int x = 0; x < 3; x++) e_hi[x] += ((sh[x] * h > ci * FS) || st);
    end
  endtask

  task automatic measure(input int n, input int exp_gap);
    bit pv[2], cur[2], rise[2], inrun[2], pend;
    int run[2], last_st;
    for (int x = 0; x < 3; x++) m_hi[x] = 0;
    m_st = 0; m_s = 0; m_both = 0; m_leg_bad = 0; m_gap_bad = 0; m_gap_seen = 0;
    pend = 0; last_st = 0;
    for (int j = 0; j < 2; j++) begin
      m_rise[j] = 0; m_wmin[j] = 1000000; m_wmax[j] = 0; inrun[j] = 0; run[j] = 0;
    end
    @(negedge clk);
    pv[0] = &(gate_hi & gate_lo);
    pv[1] = gate_boost;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cur[0] = &(gate_hi & gate_lo);
      cur[1] = gate_boost;
      for (int x = 0; x < 3; x++) m_hi[x] += gate_hi[x];
      m_st += cur[0];
      m_s  += cur[1];
      if (cur[0] && cur[1]) m_both++;
      if (!cur[0] && ((gate_hi ^ gate_lo) != 3'b111)) m_leg_bad++;
      for (int j = 0; j < 2; j++) begin
        rise[j] = cur[j] && !pv[j];
        if (rise[j]) begin
          m_rise[j]++; run[j] = 1; inrun[j] = 1;
        end else if (cur[j] && inrun[j]) begin
          run[j]++;
        end else if (!cur[j] && pv[j] && inrun[j]) begin
          if (run[j] < m_wmin[j]) m_wmin[j] = run[j];
          if (run[j] > m_wmax[j]) m_wmax[j] = run[j];
          inrun[j] = 0;
        end
        pv[j] = cur[j];
      end
      if (rise[0]) begin last_st = i; pend = 1; end
      if (rise[1] && pend) begin
        m_gap_seen++;
        if (i - last_st != exp_gap) m_gap_bad++;
        pend = 0;
      end
    end
  endtask

  task automatic apply(input int d, input int a, input int b, input int c);
    @(negedge clk);
    duty_st = W'(d); ref_a = W'(a); ref_b = W'(b); ref_c = W'(c);
    repeat (4 * cur_h + 8) @(negedge clk);
  endtask

  task automatic do_reset(input int h);
    @(negedge clk);
    rst = 1'b1; half_period = CW'(h); cur_h = (h < 3) ? 3 : h;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; half_period = 10'd48; cur_h = 48;
    duty_st = 12'd256;
    repeat (3) @(negedge clk);
    chk("R1", "gate_hi in reset", int'(gate_hi), 0);
    chk("R1", "gate_lo in reset", int'(gate_lo), 0);
    chk("R1", "gate_boost in reset", int'(gate_boost), 0);
    rst = 1'b0;
  endtask

  task automatic t_balanced();
    apply(0, 2048, 2048, 2048);
    predict(48, 0, 2048, 2048, 2048);
    measure(2 * e_per, 0);
    for (int x = 0; x < 3; x++) chk("R4", "balanced upper-gate cycles", m_hi[x], 2 * e_hi[x]);
    chk("R4", "balanced upper-gate cycles per period", e_hi[0], 47);
    chk("R5", "no shoot-through at zero duty", m_st, 0);
    chk("R7", "no boost at zero duty", m_s, 0);
    chk("R6", "legs complementary", m_leg_bad, 0);
  endtask

  task automatic t_unbalanced(input int a, input int b, input int c);
    apply(0, a, b, c);
    predict(48, 0, a, b, c);
    measure(2 * e_per, 0);
    for (int x = 0; x < 3; x++) chk("R3", "offset-shifted upper-gate cycles", m_hi[x], 2 * e_hi[x]);
    chk("R6", "legs complementary (unbalanced)", m_leg_bad, 0);
  endtask

  task automatic t_pattern(input int h, input int width);
    int per;
    apply(256, 2048, 2048, 2048);
    predict(h, 256, 2048, 2048, 2048);
    per = e_per;
    measure(4 * per, h / 3);
    chk("R5", "shoot-through cycles", m_st, 4 * e_st);
    chk("R7", "boost cycles", m_s, 4 * e_s);
    chk("R8", "shoot-through pulses", m_rise[0], 8);
    chk("R8", "boost pulses", m_rise[1], 16);
    chk("R8", "shoot-through width min", m_wmin[0], width);
    chk("R8", "shoot-through width max", m_wmax[0], width);
    chk("R8", "boost width min", m_wmin[1], width);
    chk("R8", "boost width max", m_wmax[1], width);
    chk("R2", "gap spacing mismatches", m_gap_bad, 0);
    chk("R2", "gaps observed", (m_gap_seen >= 7) ? 1 : 0, 1);
    chk("R11", "boost during shoot-through", m_both, 0);
    chk("R6", "legs outside shoot-through", m_leg_bad, 0);
  endtask

  task automatic t_clamp();
    apply(4095, 2048, 2048, 2048);
    predict(48, 4095, 2048, 2048, 2048);
    measure(2 * e_per, 16);
    chk("R10", "clamped shoot-through cycles", m_st, 2 * e_st);
    chk("R10", "clamped shoot-through cycles per period", e_st, 94);
    chk("R7", "masked boost cycles", m_s, 2 * e_s);
    chk("R11", "boost during shoot-through (overlap)", m_both, 0);
  endtask

  task automatic t_latch();
    bit prev, found;
    int hits;
    apply(0, 2048, 2048, 2048);
    found = 0; prev = gate_hi[0];
    for (int i = 0; i < 400 && !found; i++) begin
      @(negedge clk);
      if (prev && !gate_hi[0]) found = 1;
      prev = gate_hi[0];
    end
    chk("R9", "falling leg edge located", int'(found), 1);
    ref_a = 12'd4095;
    hits = 0;
    repeat (20) begin
      @(negedge clk);
      hits += gate_hi[0];
    end
    chk("R9", "upper gate before next valley", hits, 0);
    repeat (4 * cur_h + 8) @(negedge clk);
    predict(48, 0, 4095, 2048, 2048);
    measure(2 * e_per, 0);
    chk("R9", "new reference after valley", m_hi[0], 2 * e_hi[0]);
    chk("R9", "other phase after valley", m_hi[1], 2 * e_hi[1]);
  endtask

  task automatic t_min_half();
    do_reset(2);
    apply(0, 2048, 2048, 2048);
    predict(2, 0, 2048, 2048, 2048);
    measure(4 * e_per, 0);
    chk("R1", "raised half-period upper-gate cycles", m_hi[0], 4 * e_hi[0]);
  endtask

  initial begin
    t_reset();
    t_balanced();
    t_unbalanced(3000, 1000, 2000);
    t_unbalanced(1001, 2000, 3000);
    t_pattern(48, 5);
    t_clamp();
    t_latch();
    do_reset(30);
    t_pattern(30, 3);
    t_min_half();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #600000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule